// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block runs one DMA channel. Each transfer copies a single word in two bus cycles: a read from the source address, then a write of that word to the destination address. Each bus cycle walks through four bus states in order. A request input from the peripheral starts transfers. The channel keeps issuing them back to back while the request holds, until its programmed transfer count runs out.

Two request modes set when the request is re-examined. In the source-paced mode, the deposit cycle ends after its fourth state and the next fetch may follow at once. In the destination-paced mode, two idle states follow each deposit. This gives the writing device time to withdraw its request before the channel commits to another transfer. The request input is asynchronous and passes through a synchronizer first.

Software-side setup is a single load strobe that carries the start addresses, the count and a per-side increment enable. A done flag reports that the count is exhausted.

Top module: `dma_chan_seq`

## Requirements
- R1: While reset is applied, and after it is released, `ack`, `bus_ale`, `bus_rd`, `bus_wr` and `done` are low, and the channel is idle. Asserting `rst_n` clears these outputs at once, even during a transfer, and clears the loaded count.
- R2: `req_in` passes through a two-flop synchronizer. From idle with a non-zero count, a fetch T1 (`bus_ale` and `ack` high) starts on the third rising edge that samples `req_in` high.
- R3: A transfer is a fetch cycle followed by a deposit cycle, each made of T1..T4.
  - `bus_addr` carries the source address through the fetch and the destination address through the deposit.
  - `bus_ale` is high in each T1. `bus_rd` is high in fetch T2 and T3, and read data is captured at the end of fetch T3.
  - `bus_wr` is high in deposit T2 to T4, with the captured word on `bus_wdata`.
  - `ack` is high for all eight states.
- R4: With `dst_sync`=0, back-to-back fetch T1s start 8 cycles apart. Take edge 0 as the edge that starts the fetch T1. If `req_in` is first sampled low at edge 5 or earlier, the burst ends after this transfer. If it is first sampled low at edge 6, exactly one more transfer follows.
- R5: With `dst_sync`=1, two idle states with `ack` low follow each deposit, and back-to-back fetch T1s start 10 cycles apart. Counting edges from the fetch T1 edge, first sampling `req_in` low at edge 7 or earlier ends the burst. First sampling it low at edge 8 gives exactly one more transfer.
- R6: After each transfer, the source and destination addresses each advance by one when their increment enable (latched at load) is 1, and stay put when it is 0. The count drops by one.
- R7: `done` rises on the edge that ends deposit T4 of the transfer that brings the count to zero. No further transfer starts while `req_in` stays high. A later load clears `done`.
- R8: `cfg_load` takes effect only while idle and is ignored during a burst. `dst_sync` is latched as each fetch T1 begins, so a change in the middle of a transfer only affects the next one.
- R9: A loaded count of zero starts no transfer, whatever `req_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| req_in | input | 1 | Asynchronous transfer request from the peripheral |
| dst_sync | input | 1 | 0 = source-paced, 1 = destination-paced (two trailing idle states) |
| cfg_load | input | 1 | Load strobe for the setup fields, honoured only when idle |
| cfg_src | input | AW | Initial source address |
| cfg_dst | input | AW | Initial destination address |
| cfg_count | input | CW | Number of transfers |
| cfg_src_inc | input | 1 | Advance the source address after each transfer |
| cfg_dst_inc | input | 1 | Advance the destination address after each transfer |
| bus_addr | output | AW | Bus address, source in fetch, destination in deposit |
| bus_rdata | input | DW | Read data from the bus |
| bus_wdata | output | DW | Write data, valid while bus_wr is high |
| bus_ale | output | 1 | Address strobe, high in T1 of each bus cycle |
| bus_rd | output | 1 | Read strobe, fetch T2 and T3 |
| bus_wr | output | 1 | Write strobe, deposit T2 to T4 |
| ack | output | 1 | Request acknowledge, high for the whole transfer |
| done | output | 1 | Count exhausted |

## Verification
The hardest case to reach is the request sample point. A one-edge shift in when `req_in` falls decides whether the burst stops or runs one more transfer. In each mode the sample point sits at a different place behind a two-stage synchronizer. The stimulus finds the edge that starts a fetch by watching `ack` rise. It then drops `req_in` one edge before and one edge after the computed limit, and counts the fetches that follow. A mode flip in the middle of a transfer, and a load pulse in the middle of a burst, check that the latched controls hold.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_F1   = 4'd1,
    ST_F2   = 4'd2,
    ST_F3   = 4'd3,
    ST_F4   = 4'd4,
    ST_D1   = 4'd5,
    ST_D2   = 4'd6,
    ST_D3   = 4'd7,
    ST_D4   = 4'd8,
    ST_I1   = 4'd9,
    ST_I2   = 4'd10
  } seq_st_t;

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  input  logic dst_mode_in,
  input  logic cnt_zero,
  input  logic cnt_last,
  output logic idle,
  output logic capture,
  output logic xfer_end,
  output logic ack,
  output logic ale,
  output logic rd,
  output logic wr,
  output logic in_dep
);

  seq_st_t state_q, state_d;
  logic    mode_q, mode_d;   // 1 = destination-paced, latched per transfer
  logic    cont_q, cont_d;   // request seen at the sample point

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    cont_d  = cont_q;
    case (state_q)
      ST_IDLE: begin
        if (req_s && !cnt_zero) begin
          state_d = ST_F1;
          mode_d  = dst_mode_in;
        end
      end
      ST_F1: state_d = ST_F2;
      ST_F2: state_d = ST_F3;
      ST_F3: state_d = ST_F4;
      ST_F4: state_d = ST_D1;
      ST_D1: state_d = ST_D2;
      ST_D2: state_d = ST_D3;
      ST_D3: begin
        state_d = ST_D4;
        if (!mode_q) cont_d = req_s;
      end
      ST_D4: begin
        if (mode_q) begin
          state_d = ST_I1;
        end else if (cont_q && !cnt_last) begin
          state_d = ST_F1;
          mode_d  = dst_mode_in;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_I1: begin
        state_d = ST_I2;
        cont_d  = req_s;
      end
      ST_I2: begin
        if (cont_q && !cnt_zero) begin
          state_d = ST_F1;
          mode_d  = dst_mode_in;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      cont_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      cont_q  <= cont_d;
    end
  end

  always_comb begin
    idle     = (state_q == ST_IDLE);
    capture  = (state_q == ST_F3);
    xfer_end = (state_q == ST_D4);
    ale      = (state_q == ST_F1) || (state_q == ST_D1);
    rd       = (state_q == ST_F2) || (state_q == ST_F3);
    wr       = (state_q == ST_D2) || (state_q == ST_D3) || (state_q == ST_D4);
    in_dep   = (state_q == ST_D1) || (state_q == ST_D2) ||
               (state_q == ST_D3) || (state_q == ST_D4);
    ack      = (state_q != ST_IDLE) && (state_q != ST_I1) && (state_q != ST_I2);
  end

  // R3: fetch cycle hands over to deposit cycle
  p_fetch_to_deposit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_F4) |=> (state_q == ST_D1));

  // R4: source-paced deposit ends without idle states
  p_src_no_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_D4 && !mode_q) |=> (state_q == ST_F1 || state_q == ST_IDLE));

  // R5: destination-paced deposit is followed by two idle states
  p_dst_first_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_D4 && mode_q) |=> (state_q == ST_I1));
  p_dst_second_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_I1) |=> (state_q == ST_I2));

  // R8: pacing mode only changes as a fetch T1 begins
  p_mode_latched_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_F1 && state_q != ST_IDLE) |-> $stable(mode_q));

  // R9: an empty count never leaves idle
  p_no_start_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && cnt_zero) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int CW        = 16,
  parameter int ADDR_STEP = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_req,
  input  logic          idle,
  input  logic          capture,
  input  logic          xfer_end,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic [CW-1:0] ld_cnt,
  input  logic          ld_src_inc,
  input  logic          ld_dst_inc,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [DW-1:0] hold_data,
  output logic          cnt_zero,
  output logic          cnt_last,
  output logic          done
);

  localparam logic [AW-1:0] STEP = AW'(ADDR_STEP);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [AW-1:0] src_q, src_d, dst_q, dst_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] tmp_q, tmp_d;
  logic          sinc_q, sinc_d, dinc_q, dinc_d;
  logic          done_q, done_d;
  logic          load_en;

  assign load_en = load_req && idle;

  always_comb begin
    src_d  = src_q;
    dst_d  = dst_q;
    cnt_d  = cnt_q;
    tmp_d  = tmp_q;
    sinc_d = sinc_q;
    dinc_d = dinc_q;
    done_d = done_q;
    if (load_en) begin
      src_d  = ld_src;
      dst_d  = ld_dst;
      cnt_d  = ld_cnt;
      sinc_d = ld_src_inc;
      dinc_d = ld_dst_inc;
      done_d = 1'b0;
    end else if (xfer_end) begin
      if (sinc_q) src_d = src_q + STEP;
      if (dinc_q) dst_d = dst_q + STEP;
      cnt_d = cnt_q - ONE;
      if (cnt_q == ONE) done_d = 1'b1;
    end
    if (capture) tmp_d = rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      tmp_q  <= '0;
      sinc_q <= 1'b0;
      dinc_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      src_q  <= src_d;
      dst_q  <= dst_d;
      cnt_q  <= cnt_d;
      tmp_q  <= tmp_d;
      sinc_q <= sinc_d;
      dinc_q <= dinc_d;
      done_q <= done_d;
    end
  end

  assign src_addr  = src_q;
  assign dst_addr  = dst_q;
  assign hold_data = tmp_q;
  assign cnt_zero  = (cnt_q == '0);
  assign cnt_last  = (cnt_q == ONE);
  assign done      = done_q;

  // R6: each completed transfer consumes exactly one count
  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && !load_en) |=> (cnt_q == $past(cnt_q) - ONE));

  // R7: done persists until a load
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !load_en) |=> done_q);

  // R8: a load during a burst leaves the setup untouched
  p_load_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !idle && !xfer_end) |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q)));

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_STEP   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_in,
  input  logic          dst_sync,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_count,
  input  logic          cfg_src_inc,
  input  logic          cfg_dst_inc,
  output logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_ale,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          ack,
  output logic          done
);

  logic [1:0]    rst_pipe_q;
  logic          rst_int_n;
  logic          req_s;
  logic          idle, capture, xfer_end, in_dep;
  logic          cnt_zero, cnt_last;
  logic [AW-1:0] src_addr, dst_addr;
  logic [DW-1:0] hold_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (req_in),
    .q     (req_s)
  );

  dma_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_s       (req_s),
    .dst_mode_in (dst_sync),
    .cnt_zero    (cnt_zero),
    .cnt_last    (cnt_last),
    .idle        (idle),
    .capture     (capture),
    .xfer_end    (xfer_end),
    .ack         (ack),
    .ale         (bus_ale),
    .rd          (bus_rd),
    .wr          (bus_wr),
    .in_dep      (in_dep)
  );

  dma_chan_regs #(.AW(AW), .DW(DW), .CW(CW), .ADDR_STEP(ADDR_STEP)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_req   (cfg_load),
    .idle       (idle),
    .capture    (capture),
    .xfer_end   (xfer_end),
    .ld_src     (cfg_src),
    .ld_dst     (cfg_dst),
    .ld_cnt     (cfg_count),
    .ld_src_inc (cfg_src_inc),
    .ld_dst_inc (cfg_dst_inc),
    .rdata      (bus_rdata),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .hold_data  (hold_data),
    .cnt_zero   (cnt_zero),
    .cnt_last   (cnt_last),
    .done       (done)
  );

  always_comb begin
    if (in_dep)   bus_addr = dst_addr;
    else if (ack) bus_addr = src_addr;
    else          bus_addr = '0;
    bus_wdata = bus_wr ? hold_data : '0;
  end

  // R3: every strobe lies inside the acknowledge window
  p_strobe_in_ack_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_ale || bus_rd || bus_wr) |-> ack);
  p_rd_wr_apart_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(bus_rd && bus_wr));

  // R7: no acknowledge while the channel reports done
  p_quiet_when_done_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && $past(done)) |-> !$rose(ack));

endmodule

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_in, dst_sync, cfg_load, cfg_src_inc, cfg_dst_inc;
  logic [15:0] cfg_src, cfg_dst, cfg_count;
  logic [15:0] bus_addr, bus_rdata, bus_wdata;
  logic        bus_ale, bus_rd, bus_wr, ack, done;

  always #10 clk = ~clk;

  function automatic logic [15:0] mem_word(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction

  function automatic logic [15:0] exp_addr(input logic [15:0] base, input bit inc, input int k);
    return inc ? base + 16'(k) : base;
  endfunction

  function automatic int gap_of(input bit m);
    return m ? 10 : 8;
  endfunction

  assign bus_rdata = mem_word(bus_addr);

  dma_chan_seq uut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .dst_sync(dst_sync),
    .cfg_load(cfg_load), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_count(cfg_count), .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_wdata(bus_wdata),
    .bus_ale(bus_ale), .bus_rd(bus_rd), .bus_wr(bus_wr), .ack(ack), .done(done)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // bus monitor state
  logic [15:0] e_src, e_dst, last_fetch;
  bit          e_sinc, e_dinc, mon_chk;
  bit          pend, done_prev;
  int          pend_cyc, nf, nd, first_f1, last_f1, n_ack, n_rd, n_wr, done_rise;
  logic [15:0] pend_addr;

  always @(negedge clk) begin
    if (pend) begin
      if (bus_rd) begin
        if (mon_chk) chk(pend_addr == exp_addr(e_src, e_sinc, nf), "R6 fetch addr",
                         int'(pend_addr), int'(exp_addr(e_src, e_sinc, nf)));
        last_fetch = pend_addr;
        if (first_f1 < 0) first_f1 = pend_cyc;
        last_f1 = pend_cyc;
        nf++;
      end else if (bus_wr) begin
        if (mon_chk) begin
          chk(pend_addr == exp_addr(e_dst, e_dinc, nd), "R6 deposit addr",
              int'(pend_addr), int'(exp_addr(e_dst, e_dinc, nd)));
          chk(bus_wdata == mem_word(last_fetch), "R3 write data",
              int'(bus_wdata), int'(mem_word(last_fetch)));
        end
        nd++;
      end
      pend = 1'b0;
    end
    if (bus_ale) begin
      pend      = 1'b1;
      pend_addr = bus_addr;
      pend_cyc  = cyc;
    end
    if (ack)    n_ack++;
    if (bus_rd) n_rd++;
    if (bus_wr) n_wr++;
    if (done && !done_prev) done_rise = cyc;
    done_prev = done;
  end

  task automatic clear_mon();
    nf = 0; nd = 0; first_f1 = -1; last_f1 = -1;
    n_ack = 0; n_rd = 0; n_wr = 0; done_rise = -1; pend = 1'b0;
  endtask

  task automatic pulse_load(input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                            input bit si, input bit di);
    @(negedge clk);
    cfg_src = s; cfg_dst = d; cfg_count = c; cfg_src_inc = si; cfg_dst_inc = di;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic load(input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                      input bit si, input bit di);
    pulse_load(s, d, c, si, di);
    e_src = s; e_dst = d; e_sinc = si; e_dinc = di; mon_chk = 1'b1;
    clear_mon();
  endtask

  task automatic wait_ack();
    do @(negedge clk); while (!ack);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // full burst with the request held high
  task automatic run_burst(input bit m, input logic [15:0] s, input logic [15:0] d,
                           input int c, input bit si, input bit di);
    load(s, d, 16'(c), si, di);
    dst_sync = m;
    req_in   = 1'b1;
    repeat (c * 10 + 40) @(negedge clk);
    chk(nf == c, "R6 fetch count", nf, c);
    chk(nd == c, "R3 deposit count", nd, c);
    chk(done == 1'b1, "R7 done", int'(done), 1);
    chk(ack == 1'b0, "R7 ack low when done", int'(ack), 0);
    chk(last_f1 - first_f1 == (c - 1) * gap_of(m), m ? "R5 spacing" : "R4 spacing",
        last_f1 - first_f1, (c - 1) * gap_of(m));
    chk(done_rise == first_f1 + (c - 1) * gap_of(m) + 8, "R7 done timing",
        done_rise, first_f1 + (c - 1) * gap_of(m) + 8);
    chk(n_ack == 8 * c, "R3 ack length", n_ack, 8 * c);
    chk(n_rd == 2 * c && n_wr == 3 * c, "R3 strobe length", n_rd + n_wr, 5 * c);
    req_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // drop the request k edges after the fetch T1 edge; expect nexp transfers
  task automatic drop_test(input bit m, input int k, input int nexp, input string tag);
    load(16'h0100, 16'h0200, 16'd5, 1'b1, 1'b1);
    dst_sync = m;
    req_in   = 1'b1;
    wait_ack();
    repeat (k) @(negedge clk);
    req_in = 1'b0;
    repeat (40) @(negedge clk);
    chk(nf == nexp, tag, nf, nexp);
    chk(done == 1'b0, tag, int'(done), 0);
  endtask

  int t0;

  initial begin
    void'($urandom(32'd1234));
    req_in = 1'b0; dst_sync = 1'b0; cfg_load = 1'b0;
    cfg_src = '0; cfg_dst = '0; cfg_count = '0; cfg_src_inc = 1'b0; cfg_dst_inc = 1'b0;
    mon_chk = 1'b0; done_prev = 1'b0; clear_mon();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!ack && !bus_ale && !bus_rd && !bus_wr && !done, "R1 in reset", int'(ack), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!ack && !bus_ale && !bus_rd && !bus_wr && !done, "R1 after reset", int'(ack), 0);

    // R2: start latency through the synchronizer
    load(16'h0010, 16'h0020, 16'd1, 1'b1, 1'b1);
    dst_sync = 1'b0;
    @(negedge clk);
    t0 = cyc;
    req_in = 1'b1;
    repeat (12) @(negedge clk);
    chk(first_f1 == t0 + 3, "R2 start latency", first_f1, t0 + 3);
    req_in = 1'b0;
    repeat (10) @(negedge clk);

    // R9: empty count
    load(16'h0300, 16'h0400, 16'd0, 1'b1, 1'b1);
    req_in = 1'b1;
    repeat (30) @(negedge clk);
    chk(nf == 0 && n_ack == 0, "R9 empty count", nf, 0);
    req_in = 1'b0;
    repeat (4) @(negedge clk);

    // R4 and R5: request sample point, one edge either side
    drop_test(1'b0, 4, 1, "R4 stop at sample");
    drop_test(1'b0, 5, 2, "R4 one more");
    drop_test(1'b1, 6, 1, "R5 stop at sample");
    drop_test(1'b1, 7, 2, "R5 one more");

    // directed bursts, including fixed addresses
    run_burst(1'b0, 16'h1000, 16'h2000, 4, 1'b1, 1'b1);
    run_burst(1'b1, 16'h1100, 16'h2100, 3, 1'b0, 1'b1);
    run_burst(1'b0, 16'hFFFE, 16'h0005, 3, 1'b1, 1'b0);

    // R7: load clears done
    pulse_load(16'h0, 16'h0, 16'd2, 1'b0, 1'b0);
    @(negedge clk);
    chk(done == 1'b0, "R7 load clears done", int'(done), 0);

    // R8: load during a burst is ignored
    load(16'h0500, 16'h0600, 16'd3, 1'b1, 1'b1);
    dst_sync = 1'b0;
    req_in = 1'b1;
    wait_ack();
    repeat (2) @(negedge clk);
    pulse_load(16'h7777, 16'h8888, 16'd9, 1'b0, 1'b0);
    repeat (60) @(negedge clk);
    chk(nf == 3, "R8 load ignored count", nf, 3);
    chk(done == 1'b1, "R8 load ignored done", int'(done), 1);
    req_in = 1'b0;
    repeat (4) @(negedge clk);

    // R8: mode changed mid-transfer affects only the next transfer
    load(16'h0700, 16'h0800, 16'd2, 1'b1, 1'b1);
    dst_sync = 1'b0;
    req_in = 1'b1;
    wait_ack();
    t0 = cyc;
    @(negedge clk);
    dst_sync = 1'b1;
    repeat (40) @(negedge clk);
    chk(last_f1 == t0 + 8, "R8 mode latched", last_f1, t0 + 8);
    chk(done_rise == t0 + 16, "R8 mode latched done", done_rise, t0 + 16);
    req_in = 1'b0;
    dst_sync = 1'b0;
    repeat (4) @(negedge clk);

    // random bursts
    for (int i = 0; i < 10; i++) begin
      run_burst(1'($urandom % 2), 16'($urandom), 16'($urandom), 1 + int'($urandom % 5),
                1'($urandom % 2), 1'($urandom % 2));
    end

    // R1: asynchronous reset in the middle of a transfer
    load(16'h0900, 16'h0A00, 16'd4, 1'b1, 1'b1);
    req_in = 1'b1;
    wait_ack();
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!ack && !bus_rd && !bus_wr && !bus_ale && !done, "R1 reset mid transfer", int'(ack), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_chk = 1'b0;
    clear_mon();
    repeat (30) @(negedge clk);
    chk(nf == 0, "R1 count cleared by reset", nf, 0);
    req_in = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule